// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block turns a decoded instruction into its operand and effective address. Each request carries a 4-bit mode code, a 16-bit address field, a register specifier and a 2-bit indirection depth. The unit reads the named register through a combinational register-file port, and it takes the program counter and stack pointer as inputs. It then walks memory one word at a time through a request/valid read port for as many pointer and operand reads as the mode needs. When the walk is complete it returns the effective address and the operand together with a one-cycle done pulse.

A new request is taken only while the unit is idle. Address sums wrap modulo 2^16. Mode codes 10 to 15 are not defined: they finish with an illegal flag and make no memory access. Reset is asynchronous and active low. Its release passes through a two-stage synchronizer, so the unit leaves reset two clock edges after `rst_n` rises.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the address field both as the operand and as the effective address. It makes no memory access, and done rises in the first cycle after the accepting edge.
- R2: Mode code 1 (direct) uses the address field as the effective address and returns the word read there as the operand. It makes exactly one memory access.
- R3: Mode code 2 (indirect) chains depth+1 pointer reads, starting at the address field. The last pointer read is the effective address, and one more read fetches the operand. Depth 0 is single-level indirection and costs 2 accesses; depth 3 costs 5.
- R4: Mode code 3 (register) returns the contents of the named register as the operand, with effective address 0 and no memory access. Mode code 4 (register indirect) uses the register contents as the effective address and makes one access for the operand.
- R5: Mode code 5 (displacement) forms the effective address as address field + register. Mode code 6 (relative) forms it as address field + program counter. Both sums wrap modulo 2^16, and each mode makes one operand access.
- R6: Mode code 7 (preindex) reads the pointer at (address field + register) and uses that pointer as the effective address. Mode code 8 (postindex) reads the pointer at the address field and adds the register to form the effective address. Each of these modes makes two accesses.
- R7: Mode code 9 (stack) uses the stack-pointer input as the effective address and returns the word there as the operand. It makes one access and ignores the address field.
- R8: Mode codes 10 to 15 finish with illegal high alongside done, effective address 0, operand 0 and no memory access. Illegal is low with every other done.
- R9: mem_req stays high with a stable mem_addr until mem_valid is seen. Each handshake moves one word. With W wait cycles per access and N accesses, done is due 1 + N*(W+1) cycles after the accepting edge and lasts one cycle.
- R10: req_valid while busy is ignored. The running walk finishes with its own results, and no second done follows.
- R11: In reset, and after reset until a request arrives, done, busy and mem_req are low. A reset asserted during a walk returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_mode | input | 4 | Addressing mode code |
| req_addr | input | 16 | Address field of the instruction |
| req_reg | input | 3 | Register specifier |
| req_depth | input | 2 | Extra indirection levels for mode 2 |
| busy | output | 1 | Unit is not idle |
| rf_addr | output | 3 | Register-file read index |
| rf_data | input | 16 | Register-file read data |
| pc | input | 16 | Program counter |
| sp | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid, completes the handshake |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Undefined mode, valid with done |
| ea | output | 16 | Effective address |
| opnd | output | 16 | Operand |

## Verification
Each result is due a fixed number of cycles after the accepting edge. Modes without memory traffic finish one cycle later. Every memory access adds one cycle plus the memory's wait cycles, so done is due 1 + N*(W+1) cycles after acceptance. The bench counts cycles from acceptance to done and compares that count with this formula, taking N from its vector table. It runs the table twice, once with a zero-wait memory and once with a two-wait memory, and samples outputs on the falling edge of the done cycle. It also counts completed handshakes, and for the ignored-request and reset tests it watches done, busy and mem_req over the following cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [3:0] MD_IMM  = 4'd0;
  localparam logic [3:0] MD_DIR  = 4'd1;
  localparam logic [3:0] MD_IND  = 4'd2;
  localparam logic [3:0] MD_REG  = 4'd3;
  localparam logic [3:0] MD_RIND = 4'd4;
  localparam logic [3:0] MD_DISP = 4'd5;
  localparam logic [3:0] MD_REL  = 4'd6;
  localparam logic [3:0] MD_PRE  = 4'd7;
  localparam logic [3:0] MD_POST = 4'd8;
  localparam logic [3:0] MD_STK  = 4'd9;

  typedef enum logic [1:0] {BS_A, BS_REG, BS_SP} base_e;
  typedef enum logic [1:0] {OF_NONE, OF_REG, OF_PC} off_e;
  typedef enum logic [2:0] {K_IMM, K_REG, K_ILL, K_OPND, K_PTR} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_PTR, S_OPND, S_FIN} wstate_e;

  typedef struct packed {
    base_e base;
    off_e  off;
    kind_e kind;
    logic  post_add;
    logic  chain;
  } ea_dec_t;

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  output ea_dec_t    dec
);

  always_comb begin
    dec = '{base: BS_A, off: OF_NONE, kind: K_ILL, post_add: 1'b0, chain: 1'b0};
    unique case (mode)
      MD_IMM:  dec.kind = K_IMM;
      MD_DIR:  dec.kind = K_OPND;
      MD_IND:  begin dec.kind = K_PTR; dec.chain = 1'b1; end
      MD_REG:  dec.kind = K_REG;
      MD_RIND: begin dec.kind = K_OPND; dec.base = BS_REG; end
      MD_DISP: begin dec.kind = K_OPND; dec.off = OF_REG; end
      MD_REL:  begin dec.kind = K_OPND; dec.off = OF_PC; end
      MD_PRE:  begin dec.kind = K_PTR; dec.off = OF_REG; end
      MD_POST: begin dec.kind = K_PTR; dec.post_add = 1'b1; end
      MD_STK:  begin dec.kind = K_OPND; dec.base = BS_SP; end
      default: dec.kind = K_ILL;
    endcase
  end

endmodule

// File: rtl/ea_agen.sv
module ea_agen
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  base_e        base,
  input  off_e         off,
  input  logic [W-1:0] a_fld,
  input  logic [W-1:0] rval,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  output logic [W-1:0] start
);

  logic [W-1:0] base_v, off_v;

  always_comb begin
    unique case (base)
      BS_REG:  base_v = rval;
      BS_SP:   base_v = sp;
      default: base_v = a_fld;
    endcase
    unique case (off)
      OF_REG:  off_v = rval;
      OF_PC:   off_v = pc;
      default: off_v = '0;
    endcase
  end

  assign start = base_v + off_v;

endmodule

// File: rtl/ea_walk.sv
module ea_walk
  import ea_pkg::*;
#(
  parameter int W     = 16,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  kind_e            kind_i,
  input  logic             post_i,
  input  logic             chain_i,
  input  logic [W-1:0]     start_i,
  input  logic [W-1:0]     rval_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic             mem_valid,
  input  logic [W-1:0]     mem_rdata,
  output logic             busy,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  output logic             done,
  output logic             illegal,
  output logic [W-1:0]     ea,
  output logic [W-1:0]     opnd
);

  wstate_e          st_q, st_d;
  logic [W-1:0]     addr_q, addr_d, ea_q, ea_d, op_q, op_d, rv_q, rv_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             post_q, post_d, ill_q, ill_d;
  logic             accept, xfer, adv;

  assign accept = req_valid && (st_q == S_IDLE);
  assign xfer   = mem_req && mem_valid;
  assign adv    = accept || xfer || (st_q == S_FIN);

  always_comb begin
    st_d = st_q;  addr_d = addr_q; ea_d = ea_q; op_d = op_q;
    rv_d = rv_q;  lvl_d = lvl_q;   post_d = post_q; ill_d = ill_q;
    unique case (st_q)
      S_IDLE: if (accept) begin
        rv_d   = rval_i;
        post_d = post_i;
        ill_d  = 1'b0;
        lvl_d  = chain_i ? depth_i : '0;
        addr_d = start_i;
        unique case (kind_i)
          K_IMM:  begin ea_d = start_i; op_d = start_i; st_d = S_FIN; end
          K_REG:  begin ea_d = '0; op_d = rval_i; st_d = S_FIN; end
          K_OPND: begin ea_d = start_i; st_d = S_OPND; end
          K_PTR:  st_d = S_PTR;
          default: begin ea_d = '0; op_d = '0; ill_d = 1'b1; st_d = S_FIN; end
        endcase
      end
      S_PTR: if (xfer) begin
        if (lvl_q == '0) begin
          ea_d   = post_q ? (mem_rdata + rv_q) : mem_rdata;
          addr_d = ea_d;
          st_d   = S_OPND;
        end else begin
          addr_d = mem_rdata;
          lvl_d  = lvl_q - 1'b1;
        end
      end
      S_OPND: if (xfer) begin
        op_d = mem_rdata;
        st_d = S_FIN;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; addr_q <= '0; ea_q <= '0; op_q <= '0;
      rv_q <= '0; lvl_q <= '0; post_q <= 1'b0; ill_q <= 1'b0;
    end else if (adv) begin
      st_q <= st_d; addr_q <= addr_d; ea_q <= ea_d; op_q <= op_d;
      rv_q <= rv_d; lvl_q <= lvl_d; post_q <= post_d; ill_q <= ill_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign mem_req  = (st_q == S_PTR) || (st_q == S_OPND);
  assign mem_addr = addr_q;
  assign done     = (st_q == S_FIN);
  assign illegal  = done && ill_q;
  assign ea       = ea_q;
  assign opnd     = op_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R1
  no_mem_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind_i == K_IMM || kind_i == K_REG)) |=> (done && !mem_req));

  // R8
  illegal_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_i == K_ILL) |=> (done && illegal && ea == '0 && opnd == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R3
  chain_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PTR && xfer && lvl_q != '0) |=> (st_q == S_PTR && mem_addr == $past(mem_rdata)));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int W     = 16,
  parameter int RS_W  = 3,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_mode,
  input  logic [W-1:0]     req_addr,
  input  logic [RS_W-1:0]  req_reg,
  input  logic [LVL_W-1:0] req_depth,
  output logic             busy,
  output logic [RS_W-1:0]  rf_addr,
  input  logic [W-1:0]     rf_data,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     sp,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  input  logic             mem_valid,
  input  logic [W-1:0]     mem_rdata,
  output logic             done,
  output logic             illegal,
  output logic [W-1:0]     ea,
  output logic [W-1:0]     opnd
);

  logic         rst_n_s;
  ea_dec_t      dec;
  logic [W-1:0] start;

  assign rf_addr = req_reg;

  ea_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ea_decode i_decode (.mode(req_mode), .dec(dec));

  ea_agen #(.W(W)) i_agen (
    .base(dec.base), .off(dec.off), .a_fld(req_addr), .rval(rf_data),
    .pc(pc), .sp(sp), .start(start)
  );

  ea_walk #(.W(W), .LVL_W(LVL_W)) i_walk (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid),
    .kind_i(dec.kind), .post_i(dec.post_add), .chain_i(dec.chain),
    .start_i(start), .rval_i(rf_data), .depth_i(req_depth),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .done(done), .illegal(illegal), .ea(ea), .opnd(opnd)
  );

endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;

  localparam logic [15:0] PC_V = 16'h4000;
  localparam logic [15:0] SP_V = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_mode;
  logic [15:0] req_addr;
  logic [2:0]  req_reg;
  logic [1:0]  req_depth;
  logic        busy, mem_req, mem_valid, done, illegal;
  logic [2:0]  rf_addr;
  logic [15:0] rf_data, mem_addr, mem_rdata, ea, opnd;

  int tests = 0, fails = 0, acc_cnt = 0, wcnt = 0, wait_cfg = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] x);
    return {x[7:0], x[15:8]} + 16'h0137;
  endfunction

  function automatic logic [15:0] regf(input logic [2:0] i);
    return 16'hF00D + 16'h1111 * {13'd0, i};
  endfunction

  assign rf_data   = regf(rf_addr);
  assign mem_rdata = memf(mem_addr);
  assign mem_valid = mem_req && (wcnt == wait_cfg);

  always @(posedge clk) begin
    if (mem_req && mem_valid) begin acc_cnt <= acc_cnt + 1; wcnt <= 0; end
    else if (mem_req) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  ea_unit i_ea_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_reg(req_reg), .req_depth(req_depth),
    .busy(busy), .rf_addr(rf_addr), .rf_data(rf_data), .pc(PC_V), .sp(SP_V),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .ea(ea), .opnd(opnd)
  );

  typedef struct packed {
    logic [3:0]  m;
    logic [15:0] a;
    logic [2:0]  r;
    logic [1:0]  d;
    logic [3:0]  acc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  16'h1234, 3'd0, 2'd0, 4'd0},
    '{4'd1,  16'h0100, 3'd0, 2'd0, 4'd1},
    '{4'd2,  16'h0200, 3'd0, 2'd0, 4'd2},
    '{4'd2,  16'h0300, 3'd0, 2'd1, 4'd3},
    '{4'd2,  16'h0400, 3'd0, 2'd3, 4'd5},
    '{4'd3,  16'h7777, 3'd5, 2'd2, 4'd0},
    '{4'd4,  16'h0000, 3'd2, 2'd0, 4'd1},
    '{4'd5,  16'hFFF0, 3'd7, 2'd0, 4'd1},
    '{4'd6,  16'hC100, 3'd0, 2'd0, 4'd1},
    '{4'd7,  16'h0010, 3'd1, 2'd0, 4'd2},
    '{4'd8,  16'h0020, 3'd3, 2'd0, 4'd2},
    '{4'd9,  16'hABCD, 3'd0, 2'd0, 4'd1},
    '{4'd11, 16'h5555, 3'd4, 2'd1, 4'd0},
    '{4'd15, 16'h0001, 3'd6, 2'd0, 4'd0}
  };

  function automatic string tagf(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic void model(input logic [3:0] m, input logic [15:0] a,
      input logic [2:0] r, input logic [1:0] d,
      output logic [15:0] e, output logic [15:0] o, output logic il);
    logic [15:0] p;
    il = 1'b0;
    case (m)
      4'd0: begin e = a; o = a; end
      4'd1: begin e = a; o = memf(e); end
      4'd2: begin
        p = a;
        for (int i = 0; i <= int'(d); i++) p = memf(p);
        e = p; o = memf(e);
      end
      4'd3: begin e = 16'h0; o = regf(r); end
      4'd4: begin e = regf(r); o = memf(e); end
      4'd5: begin e = a + regf(r); o = memf(e); end
      4'd6: begin e = a + PC_V; o = memf(e); end
      4'd7: begin e = memf(a + regf(r)); o = memf(e); end
      4'd8: begin e = memf(a) + regf(r); o = memf(e); end
      4'd9: begin e = SP_V; o = memf(e); end
      default: begin e = 16'h0; o = 16'h0; il = 1'b1; end
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    logic [15:0] e, o;
    logic il;
    int cyc;
    string tg;
    tg = tagf(v.m);
    model(v.m, v.a, v.r, v.d, e, o, il);
    @(negedge clk);
    acc_cnt = 0;
    req_valid = 1'b1; req_mode = v.m; req_addr = v.a; req_reg = v.r; req_depth = v.d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin @(negedge clk); cyc++; end
    chk(tg, "ea", {16'h0, ea}, {16'h0, e});
    chk(tg, "opnd", {16'h0, opnd}, {16'h0, o});
    chk(tg, "illegal", {31'h0, illegal}, {31'h0, il});
    chk(tg, "accesses", acc_cnt, {28'h0, v.acc});
    chk("R9", "latency", cyc, 1 + int'(v.acc) * (wait_cfg + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] e, o;
    logic il;
    int cyc;
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_addr = '0;
    req_reg = '0; req_depth = '0;
    repeat (3) @(negedge clk);
    // R11: outputs low while in reset
    chk("R11", "done in reset", {31'h0, done}, 0);
    chk("R11", "busy in reset", {31'h0, busy}, 0);
    chk("R11", "mem_req in reset", {31'h0, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "busy after reset", {31'h0, busy}, 0);
    chk("R11", "mem_req after reset", {31'h0, mem_req}, 0);

    foreach (VECS[i]) run(VECS[i]);
    wait_cfg = 2;
    foreach (VECS[i]) run(VECS[i]);

    // R10: requests while busy are ignored
    model(4'd2, 16'h0500, 3'd0, 2'd2, e, o, il);
    @(negedge clk);
    acc_cnt = 0;
    req_valid = 1'b1; req_mode = 4'd2; req_addr = 16'h0500; req_depth = 2'd2;
    @(negedge clk);
    req_mode = 4'd0; req_addr = 16'hFFFF;
    cyc = 1;
    while (!done && cyc < 300) begin @(negedge clk); cyc++; end
    req_valid = 1'b0;
    chk("R10", "ea with busy requests", {16'h0, ea}, {16'h0, e});
    chk("R10", "opnd with busy requests", {16'h0, opnd}, {16'h0, o});
    chk("R10", "accesses", acc_cnt, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "no second done", {31'h0, done}, 0);
    end

    // R11: reset during a walk
    wait_cfg = 3;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'd2; req_addr = 16'h0600; req_depth = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "busy after mid-walk reset", {31'h0, busy}, 0);
    chk("R11", "mem_req after mid-walk reset", {31'h0, mem_req}, 0);
    chk("R11", "done after mid-walk reset", {31'h0, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wait_cfg = 1;
    run(VECS[9]);
    run(VECS[4]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule